// File: doc/BRIEF.md
# External Program and Data Bus Sequencer

This block generates the external memory bus timing for an 8051-class processor core. It divides an oscillator-period enable (`osc_tick`) into machine cycles of twelve ticks, each made of two six-tick slots. For each cycle it produces the address latch strobe, the active-low program store enable and the active-low read and write strobes. It also drives the shared low address/data byte with its output enable and the high address byte. Fetched code bytes and read data bytes are returned to the core with one-clock valid pulses. The on-chip program store is represented only by the `fetch_int` select output and the `rom_data` input.

A small state machine sets the kind of each machine cycle. The states are `CYC_FETCH`, `CYC_READ` and `CYC_WRITE`, and all of them leave reset in `CYC_FETCH`. The only transition happens on the last tick of a cycle (phase 11):
- If `acc_req` is high, the machine moves to `CYC_WRITE` when `acc_we` is 1 and to `CYC_READ` otherwise.
- If `acc_req` is low, the machine moves to `CYC_FETCH`.

The access address, write data and address-width flag are latched on that same tick. A fetch cycle performs two code fetches, one per slot. A data cycle keeps only the first address latch pulse and replaces the program strobes with one read or write strobe.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset, the machine is at phase 0 of a fetch cycle. `ale`=1, `psen_n`=1, `rd_n`=1, `wr_n`=1 and `ad_oe`=1.
- R2: A fetch cycle lasts 12 ticks, and `ale` is high at phases 0, 1, 6 and 7 (4 ticks per cycle).
- R3: In an external fetch, `psen_n` is low at phases 3-5 and 9-11 (6 ticks per cycle). The byte on `ad_in` at phase 5 is returned on `code_data`, and `code_valid` is high for one clock at phase 6.
- R4: A fetch is internal when `ea_pin`=1 and `pc` < 16'h2000; otherwise it is external. During an internal fetch `fetch_int`=1, `psen_n` stays high, and `code_data` takes `rom_data`.
- R5: While `ale` is high, `ad_out` carries the low address byte with `ad_oe`=1. During the strobe part of a fetch slot (slot phases 2-5), `ad_oe`=0.
- R6: The machine enters a data cycle when `acc_req` is high on the last tick of a cycle. In a data cycle `ale` is high only at phases 0-1 (2 ticks) and `psen_n` stays high for all 12 ticks.
- R7: In a read cycle (`acc_we`=0), `rd_n` is low at phases 3-8 (6 ticks) and `ad_oe`=0 from phase 2 onward. The byte on `ad_in` at phase 8 is returned on `rd_data`, and `rd_valid` is high for one clock at phase 9.
- R8: In a write cycle (`acc_we`=1), `wr_n` is low at phases 3-8 (6 ticks) and `ad_out` drives `acc_wdata` with `ad_oe`=1 from phase 2 to phase 11.
- R9: `a_hi` equals `pc[15:8]` in fetch cycles. In data cycles it equals `acc_addr[15:8]` when `acc_wide`=1, and the `p2_reg` value when `acc_wide`=0.
- R10: While `osc_tick` is low, the phase, the cycle kind and every strobe hold, and no valid pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-clock enable per oscillator period |
| pc | input | 16 | Program counter of the current fetch |
| ea_pin | input | 1 | External-access pin level (1 allows internal fetch) |
| acc_req | input | 1 | Request a data cycle for the next machine cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 16-bit data address, 0 = 8-bit data address |
| acc_addr | input | 16 | Data access address |
| acc_wdata | input | 8 | Data access write byte |
| p2_reg | input | 8 | Port 2 register contents |
| ad_in | input | 8 | Byte read from the shared low bus |
| rom_data | input | 8 | Byte from the internal program store |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Low address / write data byte |
| ad_oe | output | 1 | Output enable for `ad_out` |
| a_hi | output | 8 | High address byte lines |
| fetch_int | output | 1 | Current fetch is served by the internal program store |
| code_data | output | 8 | Fetched code byte |
| code_valid | output | 1 | One-clock pulse marking a new `code_data` |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | One-clock pulse marking a new `rd_data` |

## Verification
The assertions check the following on every cycle:
- Strobe exclusivity: a program strobe never overlaps `ale`, and the read strobe never overlaps the write or program strobes.
- Bus direction: released during a read strobe, driving the write byte during a write strobe.
- No second `ale` pulse in a data cycle, and `psen_n` held high during internal fetches.
- The phase range, and that state holds while the tick is low.

Only the bench scenarios can show the following:
- The exact strobe counts per machine cycle.
- The returned code and read bytes.
- The choice of fetch source at the 16'h1FFF/16'h2000 boundary under both `ea_pin` levels.
- Which source feeds `a_hi` for 16-bit and 8-bit data addresses.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
    typedef enum logic [1:0] {
        CYC_FETCH = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;
endpackage

// File: rtl/bus_phase_ctr.sv
module bus_phase_ctr #(
    parameter int CYCLE_LEN = 12,
    localparam int PH_W = $clog2(CYCLE_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    output logic [PH_W-1:0] phase,
    output logic            last
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYCLE_LEN - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (tick) begin
            phase <= last ? '0 : phase + 1'b1;
        end
    end

    assign last = (phase == PH_LAST);

    // R2: the phase never leaves the machine cycle
    assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= PH_LAST);
    // R10: no tick, no advance
    assert_phase_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase));
endmodule

// File: rtl/bus_cycle_fsm.sv
module bus_cycle_fsm
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              last,
    input  logic              acc_req,
    input  logic              acc_we,
    input  logic              acc_wide,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output cyc_e              state,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              wide_q
);
    cyc_e state_nx;
    logic boundary;

    assign boundary = tick && last;

    // next-state selection, taken only at a machine cycle boundary
    always_comb begin
        state_nx = state;
        if (boundary) begin
            if (!acc_req)    state_nx = CYC_FETCH;
            else if (acc_we) state_nx = CYC_WRITE;
            else             state_nx = CYC_READ;
        end
    end

    // state register plus the access parameters latched with it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= CYC_FETCH;
            addr_q  <= '0;
            wdata_q <= '0;
            wide_q  <= 1'b0;
        end else begin
            state <= state_nx;
            if (boundary) begin
                addr_q  <= acc_addr;
                wdata_q <= acc_wdata;
                wide_q  <= acc_wide;
            end
        end
    end

    // R6: the cycle kind changes only on the last tick of a cycle
    assert_kind_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(state));
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int SLOT_LEN  = 6,
    parameter int ALE_LEN   = 2,
    parameter int ROM_LIMIT = 16'h2000,
    localparam int CYCLE_LEN = 2 * SLOT_LEN,
    localparam int PH_W      = $clog2(CYCLE_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_e              state,
    input  logic [PH_W-1:0]   phase,
    input  logic [ADDR_W-1:0] pc,
    input  logic              ea_pin,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic              wide_q,
    input  logic [DATA_W-1:0] p2_reg,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [DATA_W-1:0] a_hi,
    output logic              fetch_int
);
    localparam int LO_W = ADDR_W - DATA_W;
    localparam logic [PH_W-1:0]   PH_SLOT   = PH_W'(SLOT_LEN);
    localparam logic [PH_W-1:0]   PH_ALE    = PH_W'(ALE_LEN);
    localparam logic [PH_W-1:0]   PH_STB    = PH_W'(ALE_LEN + 1);
    localparam logic [PH_W-1:0]   PH_DEND   = PH_W'(SLOT_LEN + ALE_LEN);
    localparam logic [ADDR_W-1:0] ROM_TOP   = ADDR_W'(ROM_LIMIT);

    logic [PH_W-1:0] slot_ph;
    logic            int_src;

    assign slot_ph = (phase >= PH_SLOT) ? phase - PH_SLOT : phase;
    assign int_src = ea_pin && (pc < ROM_TOP);

    always_comb begin
        ale       = 1'b0;
        psen_n    = 1'b1;
        rd_n      = 1'b1;
        wr_n      = 1'b1;
        ad_out    = '0;
        ad_oe     = 1'b0;
        a_hi      = p2_reg;
        fetch_int = 1'b0;
        unique case (state)
            CYC_FETCH: begin
                fetch_int = int_src;
                ale       = slot_ph < PH_ALE;
                psen_n    = int_src || (slot_ph < PH_STB);
                ad_oe     = slot_ph < PH_ALE;
                ad_out    = ad_oe ? pc[DATA_W-1:0] : '0;
                a_hi      = pc[ADDR_W-1:LO_W];
            end
            CYC_READ: begin
                ale    = phase < PH_ALE;
                rd_n   = !((phase >= PH_STB) && (phase <= PH_DEND));
                ad_oe  = ale;
                ad_out = ale ? addr_q[DATA_W-1:0] : '0;
                a_hi   = wide_q ? addr_q[ADDR_W-1:LO_W] : p2_reg;
            end
            CYC_WRITE: begin
                ale    = phase < PH_ALE;
                wr_n   = !((phase >= PH_STB) && (phase <= PH_DEND));
                ad_oe  = 1'b1;
                ad_out = ale ? addr_q[DATA_W-1:0] : wdata_q;
                a_hi   = wide_q ? addr_q[ADDR_W-1:LO_W] : p2_reg;
            end
            default: ;
        endcase
    end

    // R3: program strobe never overlaps the address latch pulse
    assert_psen_no_ale_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n |-> !ale && rd_n && wr_n);
    // R4: internal fetches keep the program strobe idle
    assert_int_no_psen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_int |-> psen_n);
    // R5: the low address is driven whenever it is being latched
    assert_ale_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe);
    // R6: no second latch pulse in a data cycle
    assert_data_one_ale_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != CYC_FETCH && phase >= PH_SLOT) |-> !ale && psen_n);
    // R7: bus released during a read strobe
    assert_rd_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe && wr_n);
    // R8: write byte driven during the write strobe
    assert_wr_drives_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe && (ad_out == wdata_q));
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int SLOT_LEN  = 6,
    parameter int ALE_LEN   = 2,
    parameter int ROM_LIMIT = 16'h2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic [ADDR_W-1:0] pc,
    input  logic              ea_pin,
    input  logic              acc_req,
    input  logic              acc_we,
    input  logic              acc_wide,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] p2_reg,
    input  logic [DATA_W-1:0] ad_in,
    input  logic [DATA_W-1:0] rom_data,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [DATA_W-1:0] a_hi,
    output logic              fetch_int,
    output logic [DATA_W-1:0] code_data,
    output logic              code_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int CYCLE_LEN = 2 * SLOT_LEN;
    localparam int PH_W      = $clog2(CYCLE_LEN);
    localparam logic [PH_W-1:0] PH_SLOT_END = PH_W'(SLOT_LEN - 1);
    localparam logic [PH_W-1:0] PH_LAST     = PH_W'(CYCLE_LEN - 1);
    localparam logic [PH_W-1:0] PH_RD_END   = PH_W'(SLOT_LEN + ALE_LEN);

    logic [PH_W-1:0]   phase;
    logic              last;
    cyc_e              state;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              wide_q;

    bus_phase_ctr #(.CYCLE_LEN(CYCLE_LEN)) u_phase (
        .clk(clk), .rst_n(rst_n), .tick(osc_tick), .phase(phase), .last(last)
    );

    bus_cycle_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(osc_tick), .last(last),
        .acc_req(acc_req), .acc_we(acc_we), .acc_wide(acc_wide),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .state(state), .addr_q(addr_q), .wdata_q(wdata_q), .wide_q(wide_q)
    );

    bus_strobe_gen #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_LEN(SLOT_LEN),
        .ALE_LEN(ALE_LEN), .ROM_LIMIT(ROM_LIMIT)
    ) u_strobe (
        .clk(clk), .rst_n(rst_n), .state(state), .phase(phase), .pc(pc),
        .ea_pin(ea_pin), .addr_q(addr_q), .wdata_q(wdata_q), .wide_q(wide_q),
        .p2_reg(p2_reg), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .fetch_int(fetch_int)
    );

    // return path: code byte at each slot end, read byte at read strobe end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_valid <= 1'b0;
            code_data  <= '0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
        end else begin
            code_valid <= 1'b0;
            rd_valid   <= 1'b0;
            if (osc_tick && state == CYC_FETCH &&
                (phase == PH_SLOT_END || phase == PH_LAST)) begin
                code_valid <= 1'b1;
                code_data  <= fetch_int ? rom_data : ad_in;
            end
            if (osc_tick && state == CYC_READ && phase == PH_RD_END) begin
                rd_valid <= 1'b1;
                rd_data  <= ad_in;
            end
        end
    end

    // R10: valid pulses only come from an advancing tick
    assert_valid_needs_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_tick |=> !code_valid && !rd_valid);
endmodule

// File: tb/ext_bus_seq_bench.sv
module ext_bus_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick = 1'b1;
    logic [15:0] pc = '0;
    logic        ea_pin = 1'b0;
    logic        acc_req = 1'b0;
    logic        acc_we = 1'b0;
    logic        acc_wide = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  p2_reg = '0;
    logic [7:0]  ad_in = '0;
    logic [7:0]  rom_data = 8'hA5;
    logic        ale, psen_n, rd_n, wr_n, ad_oe, fetch_int, code_valid, rd_valid;
    logic [7:0]  ad_out, a_hi, code_data, rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ext_bus_seq u_ext_bus_seq (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pc(pc), .ea_pin(ea_pin),
        .acc_req(acc_req), .acc_we(acc_we), .acc_wide(acc_wide),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .p2_reg(p2_reg),
        .ad_in(ad_in), .rom_data(rom_data), .ale(ale), .psen_n(psen_n),
        .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi),
        .fetch_int(fetch_int), .code_data(code_data), .code_valid(code_valid),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    typedef struct packed {
        logic        ea;
        logic        req;
        logic        we;
        logic        wide;
        logic [15:0] pcv;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [7:0]  p2;
        logic [7:0]  adin;
        logic [3:0]  n_ale;
        logic [3:0]  n_psen;
        logic [3:0]  n_rd;
        logic [3:0]  n_wr;
        logic [7:0]  ahi;
        logic [7:0]  dat;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VT [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0123, 16'h0000, 8'h00, 8'h00, 8'h5A, 4'd4, 4'd6, 4'd0, 4'd0, 8'h01, 8'h5A},
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'h1FFF, 16'h0000, 8'h00, 8'h00, 8'h5A, 4'd4, 4'd0, 4'd0, 4'd0, 8'h1F, 8'hA5},
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'h2000, 16'h0000, 8'h00, 8'h00, 8'h3C, 4'd4, 4'd6, 4'd0, 4'd0, 8'h20, 8'h3C},
        '{1'b1, 1'b1, 1'b0, 1'b1, 16'h1000, 16'h8234, 8'h00, 8'h00, 8'hC3, 4'd2, 4'd0, 4'd6, 4'd0, 8'h82, 8'hC3},
        '{1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0077, 8'h00, 8'hE1, 8'h96, 4'd2, 4'd0, 4'd6, 4'd0, 8'hE1, 8'h96},
        '{1'b0, 1'b1, 1'b1, 1'b1, 16'h0000, 16'h4455, 8'h99, 8'h00, 8'h00, 4'd2, 4'd0, 4'd0, 4'd6, 8'h44, 8'h99},
        '{1'b1, 1'b1, 1'b1, 1'b0, 16'h3000, 16'h00AB, 8'h6D, 8'h0F, 8'h00, 4'd2, 4'd0, 4'd0, 4'd6, 8'h0F, 8'h6D}
    };

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        ea_pin    = v.ea;
        acc_req   = v.req;
        acc_we    = v.we;
        acc_wide  = v.wide;
        pc        = v.pcv;
        acc_addr  = v.addr;
        acc_wdata = v.wdata;
        p2_reg    = v.p2;
        ad_in     = v.adin;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state, sampled at phase 0 before any tick edge
        check(ale == 1'b1,    "R1 ale after reset",    ale, 1);
        check(psen_n == 1'b1, "R1 psen_n after reset", psen_n, 1);
        check(rd_n && wr_n,   "R1 rd_n/wr_n after reset", {rd_n, wr_n}, 3);
        check(ad_oe == 1'b1,  "R1 ad_oe after reset",  ad_oe, 1);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int   c_ale, c_psen, c_rd, c_wr;
            logic [7:0] exp_lo;
            v = VT[i];
            apply(v);
            exp_lo = v.req ? v.addr[7:0] : v.pcv[7:0];
            repeat (12) @(negedge clk);
            c_ale = 0; c_psen = 0; c_rd = 0; c_wr = 0;
            for (int p = 0; p < 12; p++) begin
                if (ale)     c_ale++;
                if (!psen_n) c_psen++;
                if (!rd_n)   c_rd++;
                if (!wr_n)   c_wr++;
                if (p == 0) begin
                    check(ad_oe && ad_out == exp_lo, "R5 low address at phase 0", ad_out, exp_lo);
                end
                if (p == 4) begin
                    check(a_hi == v.ahi, "R9 a_hi source", a_hi, v.ahi);
                    check(ad_oe == v.we, "R5/R7/R8 ad_oe at phase 4", ad_oe, v.we);
                    if (v.we) check(ad_out == v.dat, "R8 write byte on ad_out", ad_out, v.dat);
                    if (!v.req) check(fetch_int == (v.ea && v.pcv < 16'h2000),
                                      "R4 fetch_int", fetch_int, v.ea && v.pcv < 16'h2000);
                end
                if (p == 6 && !v.req) begin
                    check(code_valid && code_data == v.dat, "R3/R4 fetched code byte", code_data, v.dat);
                end
                if (p == 9 && v.req && !v.we) begin
                    check(rd_valid && rd_data == v.dat, "R7 read data byte", rd_data, v.dat);
                end
                @(negedge clk);
            end
            check(c_ale == int'(v.n_ale),   "R2/R6 ale ticks per cycle", c_ale, v.n_ale);
            check(c_psen == int'(v.n_psen), "R3/R4/R6 psen_n low ticks", c_psen, v.n_psen);
            check(c_rd == int'(v.n_rd),     "R7 rd_n low ticks", c_rd, v.n_rd);
            check(c_wr == int'(v.n_wr),     "R8 wr_n low ticks", c_wr, v.n_wr);
        end

        // R10: stall mid-fetch with the tick held low
        apply(VT[0]);
        repeat (12) @(negedge clk);
        repeat (4) @(negedge clk);
        check(psen_n == 1'b0, "R3 psen_n low at phase 4", psen_n, 0);
        osc_tick = 1'b0;
        repeat (5) @(negedge clk);
        check(psen_n == 1'b0 && ale == 1'b0, "R10 strobes hold while stalled", {psen_n, ale}, 0);
        check(code_valid == 1'b0, "R10 no valid pulse while stalled", code_valid, 0);
        osc_tick = 1'b1;
        repeat (2) @(negedge clk);
        check(ale == 1'b1, "R10 resumes into second slot", ale, 1);
        check(code_valid && code_data == 8'h5A, "R10 code after resume", code_data, 8'h5A);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule